// File: doc/BRIEF.md
# Flash Bus Write Capture

This block connects the asynchronous parallel pins of a byte-wide flash-style bus (active-low chip enable, write enable and output enable, plus address and data) to a synchronous command path. All pins are brought into the fast clock domain through a short synchronizer pipeline, so the control, address and data samples stay aligned. A write window is open while chip enable and write enable are both low and output enable is high. The window opens on the later of the two enables to fall and closes on the first of them to rise.

The address is taken on the first sample of the window. The data is taken on the last sample of the window. When the window closes, the block checks it. Windows that are too short, that end with output enable low, or that see the low-supply flag are dropped. A window that passes yields a one-clock strobe carrying the captured address and data. A separate combinational enable tells the pad ring when to drive read data.

Top module: `wr_capture`

## Requirements
- R1: While rst_ni is low, and after it rises until a window is accepted, wr_valid_o is 0 and wr_addr_o and wr_data_o are 0.
- R2: A write window exists only on samples where ce_ni and we_ni are both 0 and oe_ni is 1. Write enable low with chip enable high, or the reverse, never yields a strobe.
- R3: wr_addr_o carries the addr_i value present on the first sample of the window, that is, when the later of ce_ni and we_ni fell. Address changes before or after that sample are ignored.
- R4: wr_data_o carries the data_i value present on the last sample of the window, just before the first of ce_ni and we_ni rose.
- R5: A window that closes on a sample where oe_ni is 0 produces no strobe.
- R6: A window shorter than MIN_PULSE samples produces no strobe. A window of exactly MIN_PULSE samples produces one.
- R7: If supply_low_i is 1 on any sample from the window's first sample through its closing sample, no strobe is produced.
- R8: Each accepted window yields wr_valid_o high for exactly one clock. wr_addr_o and wr_data_o change only together with a strobe.
- R9: With SYNC_STAGES = 2, wr_valid_o is high in the cycle that follows the third rising clock edge counted from the first edge that samples the closing pin level.
- R10: bus_oe_o is 1 exactly when ce_ni is 0, oe_ni is 0 and we_ni is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| supply_low_i | input | 1 | Digital low-supply indication, blocks writes |
| addr_i | input | ADDR_W | Address pins |
| data_i | input | DATA_W | Data pins (write direction) |
| wr_valid_o | output | 1 | One-clock strobe for an accepted write |
| wr_addr_o | output | ADDR_W | Captured address |
| wr_data_o | output | DATA_W | Captured data |
| bus_oe_o | output | 1 | Drive enable for the external data pad buffers |

## Verification
The assertions assume that every pin level lasts at least one clock. This keeps each sampled level meaningful for the window logic. They also assume that address and data are valid on the samples where the window opens and closes. The stimulus changes pins only on falling clock edges and holds each level for whole cycles. It sets address and data before the edge that opens or closes a window, so the synchronized values always line up with a real bus state. A behavioural model fed from a delay queue follows every cycle. Directed sequences cover both strobe orders, late address and data changes, short and exact-width windows, output-enable and supply inhibits, and all output-enable pin combinations.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic low;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, low: 1'b0};
endpackage

// File: rtl/wcap_sync.sv
module wcap_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wcap_fsm.sv
module wcap_fsm
  import wcap_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int MIN_W = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctl_t          ctl_s_i,
  input  logic [AW-1:0] addr_s_i,
  input  logic [DW-1:0] data_s_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_W);

  logic          act, act_q, blk, accept;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_lat;
  logic [DW-1:0] data_lat;

  assign act    = !ctl_s_i.ce_n && !ctl_s_i.we_n && ctl_s_i.oe_n;
  // close sample: window was open, now shut; oe and supply judged here too
  assign accept = act_q && !act && (cnt >= MIN_C) && !blk
                  && ctl_s_i.oe_n && !ctl_s_i.low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      blk        <= 1'b0;
      cnt        <= '0;
      addr_lat   <= '0;
      data_lat   <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) begin
        addr_lat <= addr_s_i;
        cnt      <= CW'(1);
        blk      <= ctl_s_i.low;
      end else if (act) begin
        if (cnt < MIN_C) cnt <= cnt + CW'(1);
        blk <= blk | ctl_s_i.low;
      end
      if (act) data_lat <= data_s_i;
      wr_valid_o <= accept;
      if (accept) begin
        wr_addr_o <= addr_lat;
        wr_data_o <= data_lat;
      end
    end
  end

  assert_single_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  assert_hold_between_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> $stable(wr_addr_o) && $stable(wr_data_o));

  assert_window_closed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(act_q) && !$past(act));

  assert_oe_supply_ok_R5_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(ctl_s_i.oe_n) && !$past(ctl_s_i.low) && !$past(blk));

  assert_min_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(cnt) >= MIN_C);
endmodule

// File: rtl/wr_capture.sv
module wr_capture
  import wcap_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              supply_low_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              bus_oe_o
);
  localparam int BUS_W = CTL_W + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_RST = {CTL_IDLE, {(ADDR_W + DATA_W){1'b0}}};

  ctl_t              ctl_raw, ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic [BUS_W-1:0]  bus_s;

  assign ctl_raw = '{ce_n: ce_ni, we_n: we_ni, oe_n: oe_ni, low: supply_low_i};

  // address and data ride the same pipe so they stay aligned with the strobes
  wcap_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctl_raw, addr_i, data_i}),
    .q_o   (bus_s)
  );

  assign {ctl_s, addr_s, data_s} = bus_s;

  wcap_fsm #(.AW(ADDR_W), .DW(DATA_W), .MIN_W(MIN_PULSE)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_s_i   (ctl_s),
    .addr_s_i  (addr_s),
    .data_s_i  (data_s),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  assign bus_oe_o = !ce_ni && !oe_ni && we_ni;

  assert_no_drive_in_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !bus_oe_o);
endmodule

// File: tb/test_wr_capture.sv
module test_wr_capture;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int MINW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_valid_o, bus_oe_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  always #4 clk_i = ~clk_i;

  wr_capture #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .MIN_PULSE(MINW)) i_wr_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .supply_low_i(low), .addr_i(addr), .data_i(data),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .bus_oe_o(bus_oe_o)
  );

  int checks = 0, fails = 0, dut_writes = 0;
  string tag = "R1";
  bit done = 0;

  typedef struct {bit ce; bit we; bit oe; bit lo; int a; int d;} smp_t;
  smp_t q[$];
  bit m_open, m_blk, m_valid;
  int m_cnt, m_alat, m_dlat, m_addr, m_data;

  task automatic check(string rq, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic model_step(smp_t v);
    bit act;
    act = !v.ce && !v.we && v.oe;
    m_valid = 0;
    if (m_open && !act && m_cnt >= MINW && !m_blk && v.oe && !v.lo) begin
      m_valid = 1; m_addr = m_alat; m_data = m_dlat;
    end
    if (act && !m_open) begin m_alat = v.a; m_cnt = 1; m_blk = v.lo; end
    else if (act) begin m_cnt++; m_blk = m_blk | v.lo; end
    if (act) m_dlat = v.d;
    m_open = act;
  endtask

  // reference follows every clock
  initial begin
    smp_t idle = '{1, 1, 1, 0, 0, 0};
    forever begin
      @(posedge clk_i);
      if (!rst_ni) begin
        q = {idle, idle};
        m_open = 0; m_blk = 0; m_valid = 0; m_cnt = 0;
        m_alat = 0; m_dlat = 0; m_addr = 0; m_data = 0;
      end else begin
        q.push_back('{ce_n, we_n, oe_n, low, int'(addr), int'(data)});
        model_step(q.pop_front());
        #2;
        if (wr_valid_o) dut_writes++;
        check({tag, " strobe"}, int'(wr_valid_o), int'(m_valid));
        check({tag, " addr"}, int'(wr_addr_o), m_addr);
        check({tag, " data"}, int'(wr_data_o), m_data);
        check("R10 bus_oe", int'(bus_oe_o), int'(!ce_n && !oe_n && we_n));
      end
    end
  end

  task automatic pins(bit c, bit w, bit o, bit l, int a, int d, int n);
    @(negedge clk_i);
    ce_n = c; we_n = w; oe_n = o; low = l; addr = AW'(a); data = DW'(d);
    repeat (n - 1) @(negedge clk_i);
  endtask

  task automatic expect_writes(string rq, int base, int n);
    repeat (6) @(negedge clk_i);
    check({rq, " write count"}, dut_writes - base, n);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk_i);
    check("R1 reset strobe", int'(wr_valid_o), 0);
    check("R1 reset addr", int'(wr_addr_o), 0);
    check("R1 reset data", int'(wr_data_o), 0);
    rst_ni = 1'b1;
    pins(1, 1, 1, 0, 0, 0, 4);

    // R2 R3 R4 R9: write-enable controlled window
    tag = "R9"; base = dut_writes;
    pins(0, 1, 1, 0, 'h12345, 'h00, 2);
    pins(0, 0, 1, 0, 'h12345, 'hA5, 4);
    pins(0, 1, 1, 0, 'h00111, 'h3C, 1);
    repeat (2) @(posedge clk_i); #2 check("R9 not yet", int'(wr_valid_o), 0);
    @(posedge clk_i); #2 check("R9 strobe", int'(wr_valid_o), 1);
    check("R3 addr", int'(wr_addr_o), 'h12345);
    check("R4 data", int'(wr_data_o), 'hA5);
    pins(1, 1, 1, 0, 0, 0, 3);
    expect_writes("R2", base, 1);

    // R3 R4: chip-enable controlled, late address, data change then ce rises first
    tag = "R3"; base = dut_writes;
    pins(1, 0, 1, 0, 'h7FFFF, 'h11, 3);
    pins(0, 0, 1, 0, 'h2AAAA, 'h22, 2);
    pins(0, 0, 1, 0, 'h00001, 'h5A, 2);
    pins(1, 0, 1, 0, 'h00002, 'h99, 3);
    pins(1, 1, 1, 0, 0, 0, 1);
    expect_writes("R4", base, 1);
    check("R3 late ce addr", int'(wr_addr_o), 'h2AAAA);
    check("R4 last sample data", int'(wr_data_o), 'h5A);

    // R2: only one enable low
    tag = "R2"; base = dut_writes;
    pins(1, 0, 1, 0, 'h1, 'h1, 6);
    pins(1, 1, 1, 0, 0, 0, 2);
    pins(0, 1, 1, 0, 'h2, 'h2, 6);
    pins(1, 1, 1, 0, 0, 0, 1);
    expect_writes("R2", base, 0);
    check("R2 addr untouched", int'(wr_addr_o), 'h2AAAA);

    // R5: oe low throughout, and oe falling to close the window
    tag = "R5"; base = dut_writes;
    pins(0, 0, 0, 0, 'h3, 'h3, 6);
    pins(1, 1, 1, 0, 0, 0, 2);
    pins(0, 0, 1, 0, 'h4, 'h4, 5);
    pins(0, 0, 0, 0, 'h4, 'h4, 2);
    pins(1, 1, 1, 0, 0, 0, 1);
    expect_writes("R5", base, 0);
    check("R5 data untouched", int'(wr_data_o), 'h5A);

    // R6: one sample short, then exactly the minimum
    tag = "R6"; base = dut_writes;
    pins(0, 0, 1, 0, 'h5, 'h55, MINW - 1);
    pins(1, 1, 1, 0, 0, 0, 4);
    expect_writes("R6 short", base, 0);
    base = dut_writes;
    pins(0, 0, 1, 0, 'h6, 'h66, MINW);
    pins(1, 1, 1, 0, 0, 0, 1);
    expect_writes("R6 exact", base, 1);
    check("R6 addr", int'(wr_addr_o), 'h6);

    // R7: supply low in the middle, and on the closing sample
    tag = "R7"; base = dut_writes;
    pins(0, 0, 1, 0, 'h7, 'h77, 2);
    pins(0, 0, 1, 1, 'h7, 'h77, 1);
    pins(0, 0, 1, 0, 'h7, 'h77, 3);
    pins(1, 1, 1, 0, 0, 0, 3);
    pins(0, 0, 1, 0, 'h8, 'h88, 4);
    pins(1, 1, 1, 1, 0, 0, 1);
    pins(1, 1, 1, 0, 0, 0, 1);
    expect_writes("R7", base, 0);
    check("R7 addr untouched", int'(wr_addr_o), 'h6);

    // R8: back-to-back windows
    tag = "R8"; base = dut_writes;
    pins(0, 0, 1, 0, 'h9, 'h91, 3);
    pins(0, 1, 1, 0, 'h9, 'h91, 1);
    pins(0, 0, 1, 0, 'hA, 'hA2, 3);
    pins(1, 1, 1, 0, 0, 0, 1);
    expect_writes("R8", base, 2);
    check("R8 last addr", int'(wr_addr_o), 'hA);
    check("R8 last data", int'(wr_data_o), 'hA2);

    // R10: every control combination
    tag = "R10";
    for (int i = 0; i < 8; i++) begin
      pins(i[0], i[1], i[2], 0, 0, 0, 1);
      #1 check("R10 combo", int'(bus_oe_o), int'(i == 2));
    end
    pins(1, 1, 1, 0, 0, 0, 4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule